// File: doc/BRIEF.md
# Daisy-Chain Serial Bus Node

This block sits on a serial bus that runs as a chain. Its receive line comes from the node before it and its transmit line feeds the node after it. Each byte that comes in is sent on downstream, so a command issued at the head of the chain shows up again at the tail. The first byte of a frame is a header. Bit 0 selects read or write, bits 6:1 carry a node address, and bit 7 is a blocking flag. A node with no address yet uses the blocking flag so that only the first such node in the chain accepts the address-assignment write.

A read frame addressed to this node has three bytes: header, start register and byte count. The node inserts the requested register bytes into the stream it forwards, then one CRC-8 byte. A write frame has four bytes: header, register, data and CRC-8. A write that passes its check is issued on a simple register port toward a local register file. Writing to the address register with bit 7 set gives the node its bus address.

Top module: `chain_node`

## Requirements
- R1: While reset is held and right after it is released, `tx_o` is high and `reg_wr_en` is low.
- R2: Each received byte is sent again on `tx_o` in 8N1 format, LSB first, at CLKS_PER_BIT clocks per bit. The default is 204, which gives about 612,500 bit/s from 125 MHz. Forwarded bytes keep their arrival order.
- R3: A node with no address treats a first frame byte whose bits 7:1 are all zero as blocked, and forwards it with bit 7 set (0x00 becomes 0x80, 0x01 becomes 0x81). Once the node has an address, it forwards the header unchanged.
- R4: A header selects this node when its bit 7 is 0 and its bits 6:1 equal the node address. Bit 0 = 0 means read and bit 0 = 1 means write. After reset the node address is 0 and the node is unassigned. A frame for another node produces no reply and no write.
- R5: A selected read (header, start register, count) is followed on `tx_o` by `count` register bytes from consecutive addresses, then one CRC byte. The CRC is CRC-8 with polynomial 0x07 and initial value 0. It covers the header as received, the register byte, the count byte and the data bytes.
- R6: A selected write is issued only when its fourth byte equals the CRC-8 of the first three bytes. It is issued as a one-cycle `reg_wr_en` with the register number and the data byte. A write with a wrong CRC causes no register update.
- R7: A valid write to register 0x3B with data bit 7 set makes data bits 5:0 the node address and marks the node as assigned. Later frames must use that address.
- R8: A read of 0x4C bytes starting at register 0 returns the whole register space, addresses 0 to 0x4B in order, followed by its CRC.
- R9: If no byte arrives for about 4 byte times in the middle of a frame, the frame parser returns to idle. The next byte is then treated as a header.
- R10: A byte that arrives while a reply is being produced is forwarded unchanged, is never lost, and is not parsed. The reply bytes keep their order around it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line from the previous node (idle high) |
| tx_o | output | 1 | Serial line to the next node (idle high) |
| reg_rd_addr | output | REG_AW | Register read address |
| reg_rd_data | input | 8 | Register read data, same cycle |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | REG_AW | Register write address |
| reg_wr_data | output | 8 | Register write data |

## Verification
Forwarding a received byte and producing a reply byte both push into the same transmit queue. They can try to push in the same clock cycle when upstream traffic arrives while a reply is still being produced. The bench provokes this by sending one extra byte, 0xEE, straight after a 16-byte read request, so that it lands in the middle of the reply. It judges the result by removing exactly one 0xEE from the output stream and requiring what remains to match the expected reply byte for byte. The checker also requires that the two pushes never coincide and that a forwarded byte never meets a full queue.

// File: rtl/chain_node_pkg.sv
package chain_node_pkg;
  localparam logic [7:0] CRC_POLY   = 8'h07;
  localparam logic [7:0] BLOCK_FLAG = 8'h80;
  localparam logic [7:0] ADDR_REG   = 8'h3B;

  typedef enum logic [2:0] {P_IDLE, P_HDR, P_REG, P_WCRC, P_REPLY} parse_t;

  // one byte of CRC-8, MSB first, no final xor
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  // header rewrite for a node that is still waiting for its address
  function automatic logic [7:0] header_rewrite(input logic [7:0] b, input logic blk);
    return (blk && b[7:1] == 7'd0) ? (b | BLOCK_FLAG) : b;
  endfunction
endpackage

// File: rtl/cn_uart_rx.sv
module cn_uart_rx #(
  parameter int CLKS_PER_BIT = 204
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);
  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_st_t;

  rx_st_t         st;
  logic [1:0]     sync;
  logic [CW-1:0]  cnt;
  logic [2:0]     bit_idx;
  logic [7:0]     sh;
  wire            line = sync[1];
  wire            bit_end = (cnt == CW'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; st <= R_IDLE; cnt <= '0; bit_idx <= '0;
      sh <= '0; valid_o <= 1'b0; data_o <= '0;
    end else begin
      sync    <= {sync[0], rx_i};
      valid_o <= 1'b0;
      case (st)
        R_IDLE: if (!line) begin cnt <= '0; st <= R_START; end
        R_START:
          if (cnt == CW'(CLKS_PER_BIT / 2 - 1)) begin
            cnt <= '0; bit_idx <= '0;
            st  <= line ? R_IDLE : R_DATA;
          end else cnt <= cnt + 1'b1;
        R_DATA:
          if (bit_end) begin
            cnt <= '0;
            sh  <= {line, sh[7:1]};
            if (bit_idx == 3'd7) st <= R_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        R_STOP:
          if (bit_end) begin
            st <= R_IDLE;
            if (line) begin valid_o <= 1'b1; data_o <= sh; end
          end else cnt <= cnt + 1'b1;
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cn_uart_tx.sv
module cn_uart_tx #(
  parameter int CLKS_PER_BIT = 204
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int CW = $clog2(CLKS_PER_BIT + 1);

  logic [9:0]    sh;
  logic [3:0]    nb;
  logic [CW-1:0] cnt;
  logic          busy;
  wire           bit_end = (cnt == CW'(CLKS_PER_BIT - 1));
  wire           last    = busy && bit_end && (nb == 4'd9);

  assign ready_o = !busy || last;
  assign tx_o    = busy ? sh[0] : 1'b1;
  assign busy_o  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '1; nb <= '0; cnt <= '0; busy <= 1'b0;
    end else if (ready_o && valid_i) begin
      sh <= {1'b1, data_i, 1'b0}; nb <= '0; cnt <= '0; busy <= 1'b1;
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (bit_end) begin
        cnt <= '0; sh <= {1'b1, sh[9:1]}; nb <= nb + 1'b1;
      end else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cn_txq.sv
module cn_txq #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o,
  output logic [AW:0]  count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign dout_o  = mem[rp];
  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == (AW+1)'(DEPTH));

  always_ff @(posedge clk) if (push_i) mem[wp] <= din_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count_o <= '0;
    end else begin
      if (push_i) wp <= wp + 1'b1;
      if (pop_i)  rp <= rp + 1'b1;
      count_o <= count_o + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end
endmodule

// File: rtl/cn_frame_ctl.sv
module cn_frame_ctl import chain_node_pkg::*; #(
  parameter int CLKS_PER_BIT = 204,
  parameter int REG_AW       = 7,
  parameter int QDEPTH       = 8,
  localparam int QCW         = $clog2(QDEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic [QCW-1:0]    q_count,
  output logic              fwd_push,
  output logic [7:0]        fwd_byte,
  output logic              gen_push,
  output logic [7:0]        gen_byte,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [7:0]        reg_rd_data,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [7:0]        reg_wr_data,
  output logic [5:0]        node_addr,
  output logic              gap_expire
);
  localparam int GAP_LIMIT = 50 * CLKS_PER_BIT;   // 5 byte slots between completions = 4 idle
  localparam int GW        = $clog2(GAP_LIMIT + 1);
  localparam int GEN_ROOM  = QDEPTH - 3;           // keep room for forwarded bytes

  parse_t            state;
  logic              is_wr, hit, assigned;
  logic [7:0]        regb, datab, crc, left;
  logic [REG_AW-1:0] rd_ptr;
  logic [GW-1:0]     gap;

  wire       in_frame = (state == P_HDR) || (state == P_REG) || (state == P_WCRC);
  wire [7:0] crc_next = crc8_step(crc, rx_byte);

  assign gap_expire  = in_frame && !rx_valid && (gap == GW'(GAP_LIMIT - 1));
  assign fwd_push    = rx_valid;
  assign fwd_byte    = (state == P_IDLE) ? header_rewrite(rx_byte, !assigned) : rx_byte;
  assign gen_push    = (state == P_REPLY) && !rx_valid && (q_count <= QCW'(GEN_ROOM));
  assign gen_byte    = (left != 8'd0) ? reg_rd_data : crc;
  assign reg_rd_addr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= P_IDLE; is_wr <= 1'b0; hit <= 1'b0; assigned <= 1'b0;
      regb <= '0; datab <= '0; crc <= '0; left <= '0; rd_ptr <= '0; gap <= '0;
      node_addr <= '0; reg_wr_en <= 1'b0; reg_wr_addr <= '0; reg_wr_data <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      gap <= (!in_frame || rx_valid) ? '0 : gap + 1'b1;
      if (gap_expire) state <= P_IDLE;
      else case (state)
        P_IDLE: if (rx_valid) begin
          is_wr <= rx_byte[0];
          hit   <= !rx_byte[7] && (rx_byte[6:1] == node_addr);
          crc   <= crc8_step(8'h00, rx_byte);
          state <= P_HDR;
        end
        P_HDR: if (rx_valid) begin
          regb <= rx_byte; crc <= crc_next; state <= P_REG;
        end
        P_REG: if (rx_valid) begin
          crc <= crc_next;
          if (is_wr) begin
            datab <= rx_byte; state <= P_WCRC;
          end else if (hit) begin
            left <= rx_byte; rd_ptr <= regb[REG_AW-1:0]; state <= P_REPLY;
          end else state <= P_IDLE;
        end
        P_WCRC: if (rx_valid) begin
          state <= P_IDLE;
          if (hit && rx_byte == crc) begin
            reg_wr_en   <= 1'b1;
            reg_wr_addr <= regb[REG_AW-1:0];
            reg_wr_data <= datab;
            if (regb == ADDR_REG && datab[7]) begin
              node_addr <= datab[5:0];
              assigned  <= 1'b1;
            end
          end
        end
        P_REPLY: if (gen_push) begin
          if (left != 8'd0) begin
            crc    <= crc8_step(crc, reg_rd_data);
            left   <= left - 1'b1;
            rd_ptr <= rd_ptr + 1'b1;
          end else state <= P_IDLE;
        end
        default: state <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_node.sv
module chain_node #(
  parameter int CLKS_PER_BIT = 204,
  parameter int REG_AW       = 7,
  parameter int QDEPTH       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  output logic              tx_o,
  output logic [REG_AW-1:0] reg_rd_addr,
  input  logic [7:0]        reg_rd_data,
  output logic              reg_wr_en,
  output logic [REG_AW-1:0] reg_wr_addr,
  output logic [7:0]        reg_wr_data
);
  localparam int QCW = $clog2(QDEPTH) + 1;

  logic           rx_valid;
  logic [7:0]     rx_byte;
  logic           fwd_push, gen_push, gap_expire;
  logic [7:0]     fwd_byte, gen_byte, q_dout;
  logic           q_empty, q_full, tx_ready, tx_busy;
  logic [QCW-1:0] q_count;
  logic [5:0]     node_addr;

  wire       q_push = fwd_push || gen_push;
  wire [7:0] q_din  = fwd_push ? fwd_byte : gen_byte;
  wire       q_pop  = !q_empty && tx_ready;

  cn_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .valid_o(rx_valid), .data_o(rx_byte));

  cn_frame_ctl #(.CLKS_PER_BIT(CLKS_PER_BIT), .REG_AW(REG_AW), .QDEPTH(QDEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .q_count(q_count),
    .fwd_push(fwd_push), .fwd_byte(fwd_byte), .gen_push(gen_push), .gen_byte(gen_byte),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .node_addr(node_addr),
    .gap_expire(gap_expire));

  cn_txq #(.DEPTH(QDEPTH), .W(8)) u_q (
    .clk(clk), .rst_n(rst_n), .push_i(q_push), .din_i(q_din), .pop_i(q_pop),
    .dout_o(q_dout), .empty_o(q_empty), .full_o(q_full), .count_o(q_count));

  cn_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .valid_i(!q_empty), .data_i(q_dout),
    .ready_o(tx_ready), .tx_o(tx_o), .busy_o(tx_busy));
endmodule

// File: rtl/cn_chk.sv
module cn_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fwd_push,
  input logic       gen_push,
  input logic       q_full,
  input logic       tx_busy,
  input logic       tx_o,
  input logic       rx_valid,
  input logic       reg_wr_en,
  input logic [5:0] node_addr
);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_push |-> !q_full);
  assert_single_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_push && gen_push));
  assert_tx_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_o);
  assert_wr_after_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $past(rx_valid));
  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  assert_addr_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (node_addr != $past(node_addr)) |-> reg_wr_en);
endmodule

bind chain_node cn_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fwd_push(fwd_push), .gen_push(gen_push), .q_full(q_full),
  .tx_busy(tx_busy), .tx_o(tx_o), .rx_valid(rx_valid), .reg_wr_en(reg_wr_en),
  .node_addr(node_addr));

// File: tb/chain_node_bench.sv
module chain_node_bench;
  localparam int CPB = 8;
  localparam int BT  = 10 * CPB;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic       rst_n, rx;
  logic       tx;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  logic       wr_en;
  wire  [7:0] rd_data = {1'b0, rd_addr} ^ 8'h5A;

  int checks = 0, errors = 0;
  logic [7:0] got [256];
  logic [7:0] expv [256];
  int ngot = 0, nexp = 0;
  int wr_cnt = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;
  logic decode_on = 1'b0;

  chain_node #(.CLKS_PER_BIT(CPB)) u_chain_node (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx), .reg_rd_addr(rd_addr),
    .reg_rd_data(rd_data), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data));

  // register-port monitor
  always @(posedge clk) if (rst_n && wr_en) begin
    wr_cnt = wr_cnt + 1; last_wa = wr_addr; last_wd = wr_data;
  end

  // bench-side serial decoder on tx
  initial begin
    logic [7:0] b;
    wait (decode_on);
    forever begin
      @(negedge tx);
      repeat (CPB / 2) @(negedge clk);
      if (tx == 1'b0) begin
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        if (ngot < 256) got[ngot] = b;
        ngot = ngot + 1;
      end
    end
  end

  function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx = 1'b1;
    repeat (CPB - 1) @(negedge clk);
  endtask

  task automatic clear();
    ngot = 0; nexp = 0;
  endtask

  task automatic add(input logic [7:0] b);
    expv[nexp] = b; nexp = nexp + 1;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < (n + 6) * BT && ngot < n; i++) @(negedge clk);
    repeat (4 * BT) @(negedge clk);
  endtask

  task automatic exp_read(input logic [7:0] hin, input logic [7:0] hout,
                          input logic [7:0] r, input logic [7:0] n);
    logic [7:0] c;
    add(hout); add(r); add(n);
    c = crc_add(crc_add(crc_add(8'h00, hin), r), n);
    for (int i = 0; i < int'(n); i++) begin
      logic [7:0] d = {1'b0, 7'(int'(r) + i)} ^ 8'h5A;
      add(d); c = crc_add(c, d);
    end
    add(c);
  endtask

  task automatic compare_stream(input string req);
    settle(nexp);
    check_eq(req, "byte count", ngot, nexp);
    for (int i = 0; i < nexp && i < ngot; i++)
      check_eq(req, $sformatf("byte %0d", i), int'(got[i]), int'(expv[i]));
  endtask

  task automatic send_write(input logic [7:0] h, input logic [7:0] r, input logic [7:0] d,
                            input logic good);
    logic [7:0] c = crc_add(crc_add(crc_add(8'h00, h), r), d);
    if (!good) c = c ^ 8'h01;
    send(h); send(r); send(d); send(c);
    add((h[7:1] == 7'd0 && good === 1'bx) ? h : h); add(r); add(d); add(c);
  endtask

  task automatic t_reset();
    check_eq("R1", "tx during reset", int'(tx), 1);
    check_eq("R1", "wr_en during reset", int'(wr_en), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1", "tx after reset", int'(tx), 1);
    check_eq("R1", "wr_en after reset", int'(wr_en), 0);
  endtask

  task automatic t_forward_other();   // R2 R4: frame for address 2 passes untouched
    clear();
    send(8'h04); send(8'h10); send(8'h02);
    add(8'h04); add(8'h10); add(8'h02);
    compare_stream("R2/R4 other-node read");
  endtask

  task automatic t_blocked_read();    // R3 R5: unassigned node reads at address 0
    clear();
    send(8'h00); send(8'h00); send(8'h02);
    exp_read(8'h00, 8'h80, 8'h00, 8'h02);
    compare_stream("R3/R5 blocked header and reply");
  endtask

  task automatic t_bad_crc();          // R6: wrong CRC, no write, address stays 0
    int w0 = wr_cnt;
    logic [7:0] c;
    clear();
    c = crc_add(crc_add(crc_add(8'h00, 8'h01), 8'h3B), 8'h85) ^ 8'h01;
    send(8'h01); send(8'h3B); send(8'h85); send(c);
    add(8'h81); add(8'h3B); add(8'h85); add(c);
    compare_stream("R6 bad-crc write forwarded");
    check_eq("R6", "writes after bad crc", wr_cnt, w0);
    clear();
    send(8'h0A); send(8'h3B); send(8'h01);
    add(8'h0A); add(8'h3B); add(8'h01);
    compare_stream("R6 address unchanged after bad crc");
  endtask

  task automatic t_assign();           // R7 R6 R3
    int w0 = wr_cnt;
    logic [7:0] c;
    clear();
    c = crc_add(crc_add(crc_add(8'h00, 8'h01), 8'h3B), 8'h85);
    send(8'h01); send(8'h3B); send(8'h85); send(c);
    add(8'h81); add(8'h3B); add(8'h85); add(c);
    compare_stream("R7 assignment write forwarded");
    check_eq("R6", "write count", wr_cnt, w0 + 1);
    check_eq("R7", "write addr", int'(last_wa), 'h3B);
    check_eq("R7", "write data", int'(last_wd), 'h85);
    clear();
    c = crc_add(crc_add(crc_add(8'h00, 8'h0B), 8'h30), 8'h3C);
    send(8'h0B); send(8'h30); send(8'h3C); send(c);
    add(8'h0B); add(8'h30); add(8'h3C); add(c);
    compare_stream("R6 write at new address");
    check_eq("R6", "write count 2", wr_cnt, w0 + 2);
    check_eq("R6", "write addr 2", int'(last_wa), 'h30);
    check_eq("R6", "write data 2", int'(last_wd), 'h3C);
    clear();
    send(8'h0A); send(8'h20); send(8'h03);
    exp_read(8'h0A, 8'h0A, 8'h20, 8'h03);
    compare_stream("R7 read at new address");
    clear();
    send(8'h00); send(8'h00); send(8'h01);
    add(8'h00); add(8'h00); add(8'h01);
    compare_stream("R3 assigned node, header 0 unchanged, no reply");
  endtask

  task automatic t_full_read();        // R8
    clear();
    send(8'h0A); send(8'h00); send(8'h4C);
    exp_read(8'h0A, 8'h0A, 8'h00, 8'h4C);
    compare_stream("R8 full register space");
  endtask

  task automatic t_gap();              // R9
    clear();
    send(8'h0A); send(8'h00);
    repeat (6 * BT) @(negedge clk);
    send(8'h04); send(8'h00); send(8'h02);
    add(8'h0A); add(8'h00); add(8'h04); add(8'h00); add(8'h02);
    compare_stream("R9 parser idle after gap");
  endtask

  task automatic t_overlap();          // R10
    int j = 0, skipped = 0, bad = 0;
    clear();
    send(8'h0A); send(8'h00); send(8'h10); send(8'hEE);
    exp_read(8'h0A, 8'h0A, 8'h00, 8'h10);
    settle(nexp + 1);
    check_eq("R10", "byte count", ngot, nexp + 1);
    for (int i = 0; i < ngot && i < 256; i++) begin
      if (j < nexp && got[i] == expv[j]) j = j + 1;
      else if (got[i] == 8'hEE && skipped == 0) skipped = 1;
      else bad = bad + 1;
    end
    check_eq("R10", "reply bytes in order", j, nexp);
    check_eq("R10", "extra byte forwarded once", skipped, 1);
    check_eq("R10", "unexpected bytes", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks = checks + 1; errors = errors + 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx = 1'b1;
    repeat (5) @(negedge clk);
    decode_on = 1'b1;
    t_reset();
    t_forward_other();
    t_blocked_read();
    t_bad_crc();
    t_assign();
    t_full_read();
    t_gap();
    t_overlap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule